// File: doc/BRIEF.md
# NAND Bus Width Adapter

This block connects a simple CPU-side access port to an asynchronous NAND-style device bus. One CPU access of 1, 2 or 4 bytes becomes a sequence of byte or halfword device I/O cycles. How many cycles it takes depends on three things: the device width configured for the selected chip select, the access size, and whether the access is a read or a write.

Each access targets one of three windows: command, address or data. The window decides which latch enable is held during the access. Write data goes out least significant part first. Read data is packed little-endian into the returned word.

A ready output stalls the CPU port until the final device cycle of the access has finished. Each device cycle holds its strobe for a programmable number of clocks. After the strobe, there is one clock with both strobes deasserted.

Top module: `nand_width_adapter`

## Requirements
- R1: After reset, `ready_o` is 1, every chip enable is high (inactive), both latch enables are low, both strobes are high, the output enable is low, `rdata_o` is 0, and every chip select is configured as 8-bit.
- R2: On an 8-bit device, write sizes work as follows (`size_i`: 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes). A 1-byte write issues one byte cycle, a 2-byte write issues two, and a 4-byte write issues four. Byte k of `wdata_i` (bits 8k+7..8k) goes out in cycle k on `dev_io_o[7:0]`, with `dev_io_o[15:8]` at 0.
- R3: On a 16-bit device, a 4-byte write issues two halfword cycles: `wdata_i[15:0]` first, then `wdata_i[31:16]`. A 2-byte write issues a single cycle carrying `wdata_i[15:0]`.
- R4: A 1-byte write to a 16-bit device is not rejected. It issues one halfword cycle that drives `wdata_i[15:0]`.
- R5: On an 8-bit device, byte cycle k of a read is captured from `dev_io_i[7:0]` into `rdata_o` bits 8k+7..8k. A 4-byte read takes four cycles and a 2-byte read takes two. Result bits that no cycle fills are 0.
- R6: On a 16-bit device, a 4-byte read takes two halfword cycles and returns {second, first}. A 2-byte read takes one cycle. A 1-byte read takes one halfword cycle and returns only its low 8 bits.
- R7: `win_i` selects the window: 01 = command, 10 = address, 00 or 11 = data. For the whole access, the command window holds `dev_cle_o` high and the address window holds `dev_ale_o` high. The data window holds neither. The chip enable of `cs_i` stays low for the whole access.
- R8: A configuration write stores only bit 0 of `cfg_width_i` as the width of `cfg_cs_i` (0 = 8-bit, 1 = 16-bit). Code 2 therefore behaves as 8-bit and code 3 as 16-bit.
- R9: Each device cycle holds its strobe low for `strobe_len_i` clocks, with 0 treated as 1. The length is sampled when the access is accepted. One clock with both strobes high follows each device cycle.
- R10: An access is accepted when `req_i` is high while `ready_o` is high. `ready_o` then stays low until the idle clock after the last device cycle, and requests presented while it is low are ignored.
- R11: A read on the command or address window issues no device cycle and leaves `ready_o` high. `rdata_o` is 0 from the clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 2 | Window: 01 command, 10 address, 00/11 data |
| size_i | input | 2 | 00 byte, 01 halfword, 1x word |
| cs_i | input | CS_W | Target chip select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Assembled read data |
| ready_o | output | 1 | Idle, able to accept an access |
| cfg_we_i | input | 1 | Width configuration write strobe |
| cfg_cs_i | input | CS_W | Chip select being configured |
| cfg_width_i | input | 2 | Width code; only bit 0 is kept |
| strobe_len_i | input | STRB_W | Strobe length in clocks, 0 acts as 1 |
| dev_ce_n_o | output | NUM_CS | Chip enables, active low |
| dev_cle_o | output | 1 | Command latch enable |
| dev_ale_o | output | 1 | Address latch enable |
| dev_we_n_o | output | 1 | Write strobe, active low |
| dev_re_n_o | output | 1 | Read strobe, active low |
| dev_io_o | output | 16 | Device write data |
| dev_io_oe_o | output | 1 | Device data output enable |
| dev_io_i | input | 16 | Device read data |

## Verification
The bench builds the block with NUM_CS = 4 and STRB_W = 3. With four chip selects, all four width codes can sit on separate chip selects at the same time, so the reserved codes are exercised alongside the plain ones. A 3-bit strobe field reaches its maximum of 7 clocks, so the bench covers the zero-length case, a middle length and the longest strobe. These lengths are run against both device widths and both directions.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IO_W   = 16;

  typedef enum logic [1:0] {
    WIN_DATA  = 2'd0,
    WIN_CMD   = 2'd1,
    WIN_ADDR  = 2'd2,
    WIN_DATA2 = 2'd3
  } win_e;
endpackage

// File: rtl/nwa_width_cfg.sv
module nwa_width_cfg #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned CS_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [CS_W-1:0] cfg_cs_i,
  input  logic            cfg_wide_i,
  input  logic [CS_W-1:0] sel_i,
  output logic            wide_o
);
  logic [NUM_CS-1:0] wide_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  wide_q[g] <= 1'b0;
      else if (cfg_we_i && cfg_cs_i == CS_W'(g))    wide_q[g] <= cfg_wide_i;
    end
  end

  assign wide_o = wide_q[sel_i];
endmodule

// File: rtl/nwa_beat_plan.sv
module nwa_beat_plan (
  input  logic       wide_i,
  input  logic [1:0] size_i,
  input  logic [1:0] beat_i,
  output logic [2:0] beats_o,
  output logic [4:0] shift_o
);
  always_comb begin
    case (size_i)
      2'b00:   beats_o = 3'd1;
      2'b01:   beats_o = wide_i ? 3'd1 : 3'd2;
      default: beats_o = wide_i ? 3'd2 : 3'd4;
    endcase
    shift_o = wide_i ? {beat_i[0], 4'b0000} : {beat_i, 3'b000};
  end
endmodule

// File: rtl/nwa_strobe_timer.sv
module nwa_strobe_timer #(
  parameter int unsigned STRB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic [STRB_W-1:0] len_i,
  output logic              last_o
);
  logic [STRB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + STRB_W'(1);
  end

  assign last_o = (cnt_q == len_i - STRB_W'(1));
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter import nwa_pkg::*; #(
  parameter  int unsigned NUM_CS = 4,
  parameter  int unsigned STRB_W = 4,
  localparam int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        win_i,
  input  logic [1:0]        size_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  input  logic              cfg_we_i,
  input  logic [CS_W-1:0]   cfg_cs_i,
  input  logic [1:0]        cfg_width_i,
  input  logic [STRB_W-1:0] strobe_len_i,
  output logic [NUM_CS-1:0] dev_ce_n_o,
  output logic              dev_cle_o,
  output logic              dev_ale_o,
  output logic              dev_we_n_o,
  output logic              dev_re_n_o,
  output logic [15:0]       dev_io_o,
  output logic              dev_io_oe_o,
  input  logic [15:0]       dev_io_i
);
  logic              busy_q, gap_q, wr_q, wide_q, byte_q;
  win_e              win_q;
  logic [CS_W-1:0]   cs_q;
  logic [1:0]        size_q, beat_q;
  logic [STRB_W-1:0] len_q;
  logic [WORD_W-1:0] wdata_q, acc_q, rdata_q;
  logic              wide_sel, last;
  logic [2:0]        beats;
  logic [4:0]        shift;
  logic              accept, rd_ctl, strobe;
  logic [WORD_W-1:0] cap_val, wshift;
  logic              cfg_code_unused;

  assign cfg_code_unused = cfg_width_i[1];  // reserved code bit, only bit 0 matters

  nwa_width_cfg #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_width_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_cs_i   (cfg_cs_i),
    .cfg_wide_i (cfg_width_i[0]),
    .sel_i      (cs_i),
    .wide_o     (wide_sel)
  );

  nwa_beat_plan i_beat_plan (
    .wide_i  (wide_q),
    .size_i  (size_q),
    .beat_i  (beat_q),
    .beats_o (beats),
    .shift_o (shift)
  );

  assign accept = req_i && !busy_q;
  assign rd_ctl = !we_i && (win_i == WIN_CMD || win_i == WIN_ADDR);
  assign strobe = busy_q && !gap_q;

  nwa_strobe_timer #(.STRB_W(STRB_W)) i_strobe_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept || (busy_q && gap_q)),
    .inc_i   (strobe && !last),
    .len_i   (len_q),
    .last_o  (last)
  );

  assign cap_val = (wide_q && !byte_q) ? {16'h0, dev_io_i} : {24'h0, dev_io_i[7:0]};
  assign wshift  = wdata_q >> shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      gap_q   <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      byte_q  <= 1'b0;
      win_q   <= WIN_DATA;
      cs_q    <= '0;
      size_q  <= '0;
      beat_q  <= '0;
      len_q   <= STRB_W'(1);
      wdata_q <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      wr_q    <= we_i;
      win_q   <= win_e'(win_i);
      cs_q    <= cs_i;
      size_q  <= size_i;
      wdata_q <= wdata_i;
      wide_q  <= wide_sel;
      byte_q  <= (size_i == 2'b00);
      len_q   <= (strobe_len_i == '0) ? STRB_W'(1) : strobe_len_i;
      beat_q  <= '0;
      gap_q   <= 1'b0;
      acc_q   <= '0;
      if (rd_ctl) rdata_q <= '0;
      else        busy_q  <= 1'b1;
    end else if (strobe) begin
      if (last) begin
        gap_q <= 1'b1;
        if (!wr_q) acc_q <= acc_q | (cap_val << shift);
      end
    end else if (busy_q) begin
      gap_q <= 1'b0;
      if ({1'b0, beat_q} == beats - 3'd1) begin
        busy_q <= 1'b0;
        if (!wr_q) rdata_q <= acc_q;
      end else begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign dev_ce_n_o[g] = !(busy_q && cs_q == CS_W'(g));
  end

  assign dev_cle_o   = busy_q && win_q == WIN_CMD;
  assign dev_ale_o   = busy_q && win_q == WIN_ADDR;
  assign dev_we_n_o  = !(strobe && wr_q);
  assign dev_re_n_o  = !(strobe && !wr_q);
  assign dev_io_oe_o = busy_q && wr_q;
  assign dev_io_o    = wide_q ? wshift[15:0] : {8'h00, wshift[7:0]};
  assign ready_o     = !busy_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/nwa_checker.sv
module nwa_checker #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [NUM_CS-1:0] dev_ce_n_o,
  input logic              dev_cle_o,
  input logic              dev_ale_o,
  input logic              dev_we_n_o,
  input logic              dev_re_n_o,
  input logic              dev_io_oe_o
);
  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_cle_o && dev_ale_o)); // R7

  AST_CE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dev_ce_n_o)); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dev_we_n_o && !dev_re_n_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&dev_ce_n_o && !dev_cle_o && !dev_ale_o && dev_we_n_o && dev_re_n_o && !dev_io_oe_o)); // R1

  AST_BUSY_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ($countones(~dev_ce_n_o) == 1)); // R10

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> ($stable(dev_cle_o) && $stable(dev_ale_o) && $stable(dev_ce_n_o))); // R7

  AST_GAP_BEFORE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(dev_we_n_o && dev_re_n_o)); // R9
endmodule

bind nand_width_adapter nwa_checker #(.NUM_CS(NUM_CS)) i_nwa_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .dev_ce_n_o  (dev_ce_n_o),
  .dev_cle_o   (dev_cle_o),
  .dev_ale_o   (dev_ale_o),
  .dev_we_n_o  (dev_we_n_o),
  .dev_re_n_o  (dev_re_n_o),
  .dev_io_oe_o (dev_io_oe_o)
);

// File: tb/test_nand_width_adapter.sv
module test_nand_width_adapter;
  localparam int unsigned NUM_CS = 4;
  localparam int unsigned STRB_W = 3;
  localparam int unsigned CS_W   = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [1:0]        win_i = '0, size_i = '0;
  logic [CS_W-1:0]   cs_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              ready_o;
  logic              cfg_we_i = 1'b0;
  logic [CS_W-1:0]   cfg_cs_i = '0;
  logic [1:0]        cfg_width_i = '0;
  logic [STRB_W-1:0] strobe_len_i = '0;
  logic [NUM_CS-1:0] dev_ce_n_o;
  logic              dev_cle_o, dev_ale_o, dev_we_n_o, dev_re_n_o, dev_io_oe_o;
  logic [15:0]       dev_io_o;
  logic [15:0]       dev_io_i = '0;

  always #10 clk_i = ~clk_i;

  nand_width_adapter #(.NUM_CS(NUM_CS), .STRB_W(STRB_W)) i_nand_width_adapter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .win_i(win_i),
    .size_i(size_i), .cs_i(cs_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ready_o(ready_o), .cfg_we_i(cfg_we_i), .cfg_cs_i(cfg_cs_i),
    .cfg_width_i(cfg_width_i), .strobe_len_i(strobe_len_i),
    .dev_ce_n_o(dev_ce_n_o), .dev_cle_o(dev_cle_o), .dev_ale_o(dev_ale_o),
    .dev_we_n_o(dev_we_n_o), .dev_re_n_o(dev_re_n_o), .dev_io_o(dev_io_o),
    .dev_io_oe_o(dev_io_oe_o), .dev_io_i(dev_io_i)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: one queue entry per expected clock of device activity
  typedef struct {
    bit          strobe;
    bit          wr;
    int          win;
    int          cs;
    logic [15:0] io;
    int          beat;
    bit          cap;
    bit          cap16;
    int          shift;
  } ent_t;

  ent_t        mq[$];
  bit          m_width[NUM_CS];
  logic [31:0] m_acc = '0, m_rdata = '0;
  logic [15:0] rd_words[4] = '{16'hC3A1, 16'h5E72, 16'h9B04, 16'h17FD};

  function automatic void plan(bit we, int win, int size, int cs, logic [31:0] wd, int len);
    bit wide;
    int n, beats;
    wide  = m_width[cs];
    n     = (len == 0) ? 1 : len;
    m_acc = '0;
    if (!we && (win == 1 || win == 2)) begin
      m_rdata = '0;
      return;
    end
    beats = (size == 0) ? 1 : (size == 1) ? (wide ? 1 : 2) : (wide ? 2 : 4);
    for (int b = 0; b < beats; b++) begin
      ent_t        e;
      logic [31:0] ws;
      ws      = wd >> (b * (wide ? 16 : 8));
      e.wr    = we;
      e.win   = win;
      e.cs    = cs;
      e.io    = wide ? ws[15:0] : {8'h00, ws[7:0]};
      e.beat  = b;
      e.cap16 = wide && (size != 0);
      e.shift = b * (wide ? 16 : 8);
      for (int k = 0; k < n; k++) begin
        e.strobe = 1'b1;
        e.cap    = (k == n - 1) && !we;
        mq.push_back(e);
      end
      e.strobe = 1'b0;
      e.cap    = 1'b0;
      mq.push_back(e);
    end
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mq.delete();
      m_rdata = '0;
      m_acc   = '0;
      for (int i = 0; i < NUM_CS; i++) m_width[i] = 1'b0;
    end else begin
      if (mq.size() == 0) begin
        if (req_i) plan(we_i, int'(win_i), int'(size_i), int'(cs_i), wdata_i, int'(strobe_len_i));
      end else begin
        ent_t        e;
        logic [31:0] cv;
        e = mq.pop_front();
        if (e.cap) begin
          cv    = e.cap16 ? {16'h0, dev_io_i} : {24'h0, dev_io_i[7:0]};
          m_acc = m_acc | (cv << e.shift);
        end
        if (mq.size() == 0 && !e.wr) m_rdata = m_acc;
      end
      if (cfg_we_i) m_width[cfg_cs_i] = cfg_width_i[0];
    end
  end

  // per-clock comparison away from the active edge, then drive device read data
  always @(negedge clk_i) begin
    bit                busy;
    logic [NUM_CS-1:0] ce_exp;
    logic [NUM_CS+5:0] act_v, exp_v;
    if (rst_ni && !done) begin
      busy   = (mq.size() != 0);
      ce_exp = '1;
      if (busy) ce_exp[mq[0].cs] = 1'b0;
      exp_v = {!busy, ce_exp,
               busy && mq[0].win == 1, busy && mq[0].win == 2,
               !(busy && mq[0].strobe && mq[0].wr),
               !(busy && mq[0].strobe && !mq[0].wr),
               busy && mq[0].wr};
      act_v = {ready_o, dev_ce_n_o, dev_cle_o, dev_ale_o, dev_we_n_o, dev_re_n_o, dev_io_oe_o};
      chk(act_v === exp_v, cur_req, "pins{rdy,ce_n,cle,ale,we_n,re_n,oe}", 32'(act_v), 32'(exp_v));
      if (busy && mq[0].strobe && mq[0].wr)
        chk(dev_io_o === mq[0].io, cur_req, "dev_io_o", 32'(dev_io_o), 32'(mq[0].io));
      chk(rdata_o === m_rdata, cur_req, "rdata_o", rdata_o, m_rdata);
      dev_io_i = busy ? rd_words[mq[0].beat] : 16'h0000;
    end
  end

  task automatic cfg(int cs, logic [1:0] code);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_cs_i = CS_W'(cs); cfg_width_i = code;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic acc(bit we, logic [1:0] win, logic [1:0] size, int cs, logic [31:0] wd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; win_i = win; size_i = size; cs_i = CS_W'(cs); wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    while (mq.size() != 0) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state R1
    chk(ready_o === 1'b1 && &dev_ce_n_o && !dev_cle_o && !dev_ale_o && dev_we_n_o && dev_re_n_o && !dev_io_oe_o,
        "R1", "reset pins", {25'h0, ready_o, dev_cle_o, dev_ale_o, dev_we_n_o, dev_re_n_o, dev_io_oe_o, 1'b0}, 32'h00000000);
    chk(rdata_o === 32'h0, "R1", "reset rdata", rdata_o, 32'h0);
    rst_ni = 1'b1;
    strobe_len_i = 3'd1;

    cur_req = "R8";
    cfg(0, 2'd0); cfg(1, 2'd1); cfg(2, 2'd2); cfg(3, 2'd3);

    cur_req = "R2";
    acc(1, 2'd0, 2'd2, 0, 32'h11223344);
    acc(1, 2'd0, 2'd1, 0, 32'h55667788);
    acc(1, 2'd0, 2'd0, 0, 32'h99AABBCC);

    cur_req = "R3";
    acc(1, 2'd0, 2'd2, 1, 32'h12345678);
    acc(1, 2'd0, 2'd1, 1, 32'h9ABCDEF0);

    cur_req = "R4";
    acc(1, 2'd0, 2'd0, 1, 32'h0000ABCD);

    cur_req = "R7";
    acc(1, 2'd1, 2'd0, 0, 32'h00000070);
    acc(1, 2'd2, 2'd2, 1, 32'h0A0B0C0D);
    acc(1, 2'd3, 2'd1, 2, 32'h00004321);

    cur_req = "R5";
    acc(0, 2'd0, 2'd2, 0, 32'h0);
    chk(rdata_o === 32'hFD0472A1, "R5", "8-bit word read", rdata_o, 32'hFD0472A1);
    acc(0, 2'd0, 2'd1, 0, 32'h0);
    chk(rdata_o === 32'h000072A1, "R5", "8-bit half read", rdata_o, 32'h000072A1);

    cur_req = "R6";
    acc(0, 2'd0, 2'd2, 1, 32'h0);
    chk(rdata_o === 32'h5E72C3A1, "R6", "16-bit word read", rdata_o, 32'h5E72C3A1);
    acc(0, 2'd0, 2'd0, 1, 32'h0);
    chk(rdata_o === 32'h000000A1, "R6", "16-bit byte read", rdata_o, 32'h000000A1);

    cur_req = "R11";
    acc(0, 2'd0, 2'd1, 1, 32'h0);
    acc(0, 2'd1, 2'd2, 0, 32'h0);
    chk(rdata_o === 32'h0, "R11", "command-window read", rdata_o, 32'h0);
    chk(ready_o === 1'b1, "R11", "ready after control read", {31'h0, ready_o}, 32'h1);

    cur_req = "R8";
    acc(1, 2'd0, 2'd2, 2, 32'hA1B2C3D4);
    acc(0, 2'd0, 2'd2, 3, 32'h0);
    chk(rdata_o === 32'h5E72C3A1, "R8", "code 3 acts 16-bit", rdata_o, 32'h5E72C3A1);
    cfg(0, 2'd3);
    acc(1, 2'd0, 2'd2, 0, 32'hF0E1D2C3);

    cur_req = "R9";
    strobe_len_i = 3'd0;
    acc(1, 2'd0, 2'd1, 1, 32'h00001357);
    strobe_len_i = 3'd3;
    acc(0, 2'd0, 2'd2, 2, 32'h0);
    chk(rdata_o === 32'hFD0472A1, "R9", "read with 3-clock strobe", rdata_o, 32'hFD0472A1);
    strobe_len_i = 3'd7;
    acc(1, 2'd1, 2'd2, 3, 32'h2468ACE0);
    acc(0, 2'd0, 2'd2, 0, 32'h0);
    chk(rdata_o === 32'h5E72C3A1, "R9", "read with 7-clock strobe", rdata_o, 32'h5E72C3A1);

    cur_req = "R10";
    strobe_len_i = 3'd1;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; win_i = 2'd0; size_i = 2'd2; cs_i = 2'd2; wdata_i = 32'hCAFEF00D;
    @(negedge clk_i);
    wdata_i = 32'hDEADBEEF; cs_i = 2'd1; win_i = 2'd1; we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    req_i = 1'b0;
    while (mq.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
    chk(ready_o === 1'b1 && &dev_ce_n_o, "R10", "idle after ignored requests",
        {27'h0, ready_o, dev_ce_n_o}, 32'h0000001F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule